// File: doc/BRIEF.md
# Hardware Scheduling State Machine

This block stands in for the scheduler of a software real-time kernel when the application is fixed and fully known ahead of time. It keeps one abstract system state and, for every encoded system event it accepts, looks up a precomputed transition that gives the next system state and the hardware thread that must run next. Events reach it from a syscall instruction in the pipeline or from the alarm generator, one per transaction, through a valid/ready handshake.

The transition function is a synthesis-time parameter: a packed table indexed by the concatenation {state, event}. No ready list is kept and no priority comparison is made. Every application thread and the idle thread own a hardware thread; interrupt handlers run on whichever thread is current, so a handler state keeps the interrupted thread's identifier. The result of each accepted event is presented for one cycle with a strobe, a flag telling whether the running thread changed, and an error flag when the table has no entry for that event in that state.

The default table models one periodic thread `T` plus the idle thread. Controller states: `CTL_WAIT` (ready for an event) and `CTL_DONE` (result cycle); an accepted event moves `CTL_WAIT` to `CTL_DONE`, which always returns to `CTL_WAIT`. System states (3-bit codes): `SYS_IDLE`=0, `SYS_HND_IDLE`=1 (handler entered from idle), `SYS_HND_ACT`=2 (handler has activated T), `SYS_T_RUN`=3, `SYS_HND_T`=4 (handler entered while T runs). Transitions: `SYS_IDLE`-isr->`SYS_HND_IDLE`; `SYS_HND_IDLE`-activate->`SYS_HND_ACT`; `SYS_HND_IDLE`-iret->`SYS_IDLE`; `SYS_HND_ACT`-iret->`SYS_T_RUN`; `SYS_T_RUN`-terminate->`SYS_IDLE`; `SYS_T_RUN`-isr->`SYS_HND_T`; `SYS_HND_T`-activate->`SYS_HND_T`; `SYS_HND_T`-iret->`SYS_T_RUN`.

Top module: `hsm_core`

## Requirements
- R1: While and after reset, sys_state is 0 (`SYS_IDLE`), run_thread is 0 (idle), out_valid, resched and bad_event are 0, and event_ready is 1.
- R2: An event is accepted at a rising edge where event_valid and event_ready are both 1; out_valid is then 1 for exactly the following cycle, during which event_ready is 0, and event_ready returns to 1 the cycle after.
- R3: With the default table, event codes are isr=3'b001, iret=3'b010, terminate=3'b011, activate-T=3'b101, and thread codes are idle=0, T=1; an accepted event sets sys_state and run_thread as listed in the transitions above, with the handler states keeping the thread that was running (0 in `SYS_HND_IDLE` and `SYS_HND_ACT`, 1 in `SYS_HND_T`).
- R4: resched is 1 in the result cycle exactly when the new run_thread differs from the one before the event, and is 0 in every other cycle.
- R5: An event code with no table entry for the current state (every pair not listed above, including code 0, 3'b100, 3'b110, 3'b111) leaves sys_state and run_thread unchanged, sets bad_event for the result cycle and keeps resched at 0.
- R6: An activate-T event while T is already active (`SYS_HND_T`) is a valid no-op: state and thread stay, no resched, no bad_event, and the following iret resumes T without resched.
- R7: sys_state and run_thread change only in the cycle after an accepted event and otherwise hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| event_valid | input | 1 | An event code is offered |
| event_code | input | EVW (3) | Encoded system event |
| event_ready | output | 1 | Block can take an event this cycle |
| out_valid | output | 1 | Result of the last accepted event is presented |
| run_thread | output | TW (1) | Hardware thread selected to run |
| sys_state | output | SW (3) | Current abstract system state code |
| resched | output | 1 | Running thread changed with this result |
| bad_event | output | 1 | Event had no entry for the state it arrived in |

## Verification
Every result is due one cycle after acceptance: the event is offered after a falling edge, accepted at the next rising edge, and out_valid, sys_state, run_thread, resched and bad_event are all sampled at the falling edge that follows, with the ready recovery checked one cycle later. The bench drives the machine into each of the five reachable states by reset plus a short event prefix and then applies all eight event codes, comparing against a model of the transition list. Hold behaviour is checked by idling several cycles after an event and confirming that nothing moved.

// File: rtl/hsm_pkg.sv
package hsm_pkg;

    localparam int DEF_SW  = 3;
    localparam int DEF_EVW = 3;
    localparam int DEF_TW  = 1;
    localparam int DEF_EW  = 1 + DEF_SW + DEF_TW;
    localparam int DEF_ENTRIES = 2 ** (DEF_SW + DEF_EVW);

    localparam logic [DEF_EVW-1:0] EV_ISR   = 3'b001;
    localparam logic [DEF_EVW-1:0] EV_IRET  = 3'b010;
    localparam logic [DEF_EVW-1:0] EV_TERM  = 3'b011;
    localparam logic [DEF_EVW-1:0] EV_ACT_T = 3'b101;

    localparam logic [DEF_SW-1:0] SYS_IDLE     = 3'd0;
    localparam logic [DEF_SW-1:0] SYS_HND_IDLE = 3'd1;
    localparam logic [DEF_SW-1:0] SYS_HND_ACT  = 3'd2;
    localparam logic [DEF_SW-1:0] SYS_T_RUN    = 3'd3;
    localparam logic [DEF_SW-1:0] SYS_HND_T    = 3'd4;

    localparam logic [DEF_TW-1:0] TH_IDLE = 1'b0;
    localparam logic [DEF_TW-1:0] TH_T    = 1'b1;

    typedef enum logic [0:0] {CTL_WAIT, CTL_DONE} ctl_e;

    function automatic int slot(logic [DEF_SW-1:0] s, logic [DEF_EVW-1:0] e);
        return int'({s, e}) * DEF_EW;
    endfunction

    // Entry layout: {hit, next_state, next_thread}
    function automatic logic [DEF_ENTRIES*DEF_EW-1:0] default_table();
        logic [DEF_ENTRIES*DEF_EW-1:0] t;
        t = '0;
        t[slot(SYS_IDLE,     EV_ISR)   +: DEF_EW] = {1'b1, SYS_HND_IDLE, TH_IDLE};
        t[slot(SYS_HND_IDLE, EV_ACT_T) +: DEF_EW] = {1'b1, SYS_HND_ACT,  TH_IDLE};
        t[slot(SYS_HND_IDLE, EV_IRET)  +: DEF_EW] = {1'b1, SYS_IDLE,     TH_IDLE};
        t[slot(SYS_HND_ACT,  EV_IRET)  +: DEF_EW] = {1'b1, SYS_T_RUN,    TH_T};
        t[slot(SYS_T_RUN,    EV_TERM)  +: DEF_EW] = {1'b1, SYS_IDLE,     TH_IDLE};
        t[slot(SYS_T_RUN,    EV_ISR)   +: DEF_EW] = {1'b1, SYS_HND_T,    TH_T};
        t[slot(SYS_HND_T,    EV_ACT_T) +: DEF_EW] = {1'b1, SYS_HND_T,    TH_T};
        t[slot(SYS_HND_T,    EV_IRET)  +: DEF_EW] = {1'b1, SYS_T_RUN,    TH_T};
        return t;
    endfunction

endpackage

// File: rtl/hsm_lookup.sv
module hsm_lookup #(
    parameter int SW  = 3,
    parameter int EVW = 3,
    parameter int TW  = 1,
    parameter logic [(2**(SW+EVW))*(1+SW+TW)-1:0] TABLE = '0
) (
    input  logic [SW-1:0]  cur_state,
    input  logic [EVW-1:0] ev_code,
    output logic           hit,
    output logic [SW-1:0]  nxt_state,
    output logic [TW-1:0]  nxt_thread
);
    localparam int EW = 1 + SW + TW;

    logic [EW-1:0] entry;

    always_comb begin
        entry      = TABLE[int'({cur_state, ev_code}) * EW +: EW];
        hit        = entry[EW-1];
        nxt_state  = entry[TW +: SW];
        nxt_thread = entry[TW-1:0];
    end
endmodule

// File: rtl/hsm_ctrl.sv
module hsm_ctrl
    import hsm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic event_valid,
    output logic event_ready,
    output logic accept,
    output logic out_valid
);
    ctl_e ctl_q, ctl_d;

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q)
            CTL_WAIT: if (event_valid) ctl_d = CTL_DONE;
            CTL_DONE: ctl_d = CTL_WAIT;
            default:  ctl_d = CTL_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_WAIT;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        event_ready = 1'b0;
        out_valid   = 1'b0;
        unique case (ctl_q)
            CTL_WAIT: event_ready = 1'b1;
            CTL_DONE: out_valid   = 1'b1;
            default:  event_ready = 1'b0;
        endcase
        accept = event_ready && event_valid;
    end
endmodule

// File: rtl/hsm_core.sv
module hsm_core #(
    parameter int SW  = hsm_pkg::DEF_SW,
    parameter int EVW = hsm_pkg::DEF_EVW,
    parameter int TW  = hsm_pkg::DEF_TW,
    parameter logic [SW-1:0] RESET_STATE  = '0,
    parameter logic [TW-1:0] RESET_THREAD = '0,
    parameter logic [(2**(SW+EVW))*(1+SW+TW)-1:0] TABLE = hsm_pkg::default_table()
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           event_valid,
    input  logic [EVW-1:0] event_code,
    output logic           event_ready,
    output logic           out_valid,
    output logic [TW-1:0]  run_thread,
    output logic [SW-1:0]  sys_state,
    output logic           resched,
    output logic           bad_event
);
    logic          accept;
    logic          hit;
    logic [SW-1:0] nxt_state;
    logic [TW-1:0] nxt_thread;
    logic [SW-1:0] state_q;
    logic [TW-1:0] thread_q;
    logic          resched_q;
    logic          bad_q;

    hsm_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .event_valid (event_valid),
        .event_ready (event_ready),
        .accept      (accept),
        .out_valid   (out_valid)
    );

    hsm_lookup #(.SW(SW), .EVW(EVW), .TW(TW), .TABLE(TABLE)) u_lookup (
        .cur_state  (state_q),
        .ev_code    (event_code),
        .hit        (hit),
        .nxt_state  (nxt_state),
        .nxt_thread (nxt_thread)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= RESET_STATE;
            thread_q  <= RESET_THREAD;
            resched_q <= 1'b0;
            bad_q     <= 1'b0;
        end else if (accept && hit) begin
            state_q   <= nxt_state;
            thread_q  <= nxt_thread;
            resched_q <= (nxt_thread != thread_q);
            bad_q     <= 1'b0;
        end else if (accept) begin
            resched_q <= 1'b0;
            bad_q     <= 1'b1;
        end else begin
            resched_q <= 1'b0;
            bad_q     <= 1'b0;
        end
    end

    always_comb begin
        sys_state  = state_q;
        run_thread = thread_q;
        resched    = resched_q;
        bad_event  = bad_q;
    end
endmodule

// File: rtl/hsm_core_chk.sv
module hsm_core_chk #(
    parameter int SW  = 3,
    parameter int EVW = 3,
    parameter int TW  = 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic           event_valid,
    input logic [EVW-1:0] event_code,
    input logic           event_ready,
    input logic           out_valid,
    input logic [TW-1:0]  run_thread,
    input logic [SW-1:0]  sys_state,
    input logic           resched,
    input logic           bad_event
);
    AST_RESULT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (event_valid && event_ready) |=> out_valid);  // R2
    AST_RESULT_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(event_valid && event_ready));  // R2
    AST_NOT_READY_IN_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !event_ready);  // R2
    AST_RESCHED_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        resched |-> (out_valid && run_thread != $past(run_thread)));  // R4
    AST_CHANGE_GIVES_RESCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && run_thread != $past(run_thread)) |-> resched);  // R4
    AST_BAD_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        bad_event |-> (out_valid && $stable(sys_state) && $stable(run_thread)));  // R5
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({resched, bad_event}));  // R5
    AST_HOLD_WITHOUT_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(event_valid && event_ready) |-> ($stable(sys_state) && $stable(run_thread)));  // R7
endmodule

bind hsm_core hsm_core_chk #(.SW(SW), .EVW(EVW), .TW(TW)) u_chk (.*);

// File: tb/sim_hsm_core.sv
`timescale 1ns/100ps
module sim_hsm_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       event_valid = 1'b0;
    logic [2:0] event_code = 3'd0;
    logic       event_ready, out_valid, resched, bad_event;
    logic [0:0] run_thread;
    logic [2:0] sys_state;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // model of the expected system
    logic [2:0] m_state;
    logic       m_thread;

    always #2.5 clk = ~clk;

    hsm_core u0 (
        .clk(clk), .rst_n(rst_n), .event_valid(event_valid), .event_code(event_code),
        .event_ready(event_ready), .out_valid(out_valid), .run_thread(run_thread),
        .sys_state(sys_state), .resched(resched), .bad_event(bad_event)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected transition per R3/R5/R6: returns hit, next state, next thread
    task automatic model(input logic [2:0] s, input logic [2:0] e,
                         output bit hit, output logic [2:0] ns, output logic nt);
        hit = 1; ns = s; nt = m_thread;
        if      (s == 3'd0 && e == 3'b001) begin ns = 3'd1; nt = 1'b0; end
        else if (s == 3'd1 && e == 3'b101) begin ns = 3'd2; nt = 1'b0; end
        else if (s == 3'd1 && e == 3'b010) begin ns = 3'd0; nt = 1'b0; end
        else if (s == 3'd2 && e == 3'b010) begin ns = 3'd3; nt = 1'b1; end
        else if (s == 3'd3 && e == 3'b011) begin ns = 3'd0; nt = 1'b0; end
        else if (s == 3'd3 && e == 3'b001) begin ns = 3'd4; nt = 1'b1; end
        else if (s == 3'd4 && e == 3'b101) begin ns = 3'd4; nt = 1'b1; end
        else if (s == 3'd4 && e == 3'b010) begin ns = 3'd3; nt = 1'b1; end
        else hit = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        event_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk(sys_state == 3'd0 && run_thread == 1'b0, "R1", "reset state/thread",
            int'({sys_state, run_thread}), 0);
        chk(!out_valid && !resched && !bad_event && event_ready, "R1", "reset flags",
            int'({out_valid, resched, bad_event, event_ready}), 1);
        rst_n = 1'b1;
        m_state = 3'd0;
        m_thread = 1'b0;
    endtask

    task automatic send(input logic [2:0] e);
        bit hit;
        logic [2:0] ns;
        logic nt;
        logic old_t;
        string req;
        model(m_state, e, hit, ns, nt);
        old_t = m_thread;
        event_code = e;
        event_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        event_valid = 1'b0;
        chk(out_valid && !event_ready, "R2", "result strobe/ready",
            int'({out_valid, event_ready}), 2);
        if (!hit) req = "R5";
        else if (m_state == 3'd4 && e == 3'b101) req = "R6";
        else req = "R3";
        chk(sys_state == (hit ? ns : m_state), req, "state", int'(sys_state), int'(hit ? ns : m_state));
        chk(run_thread == (hit ? nt : old_t), req, "thread", int'(run_thread), int'(hit ? nt : old_t));
        chk(bad_event == !hit, "R5", "bad_event", int'(bad_event), int'(!hit));
        chk(resched == (hit && nt != old_t), "R4", "resched", int'(resched), int'(hit && nt != old_t));
        if (hit) begin
            m_state = ns;
            m_thread = nt;
        end
        @(negedge clk);
        chk(!out_valid && event_ready && !resched && !bad_event, "R2", "return to ready",
            int'({out_valid, event_ready, resched, bad_event}), 4);
    endtask

    task automatic prefix(input int target);
        if (target >= 1) send(3'b001);
        if (target >= 2) send(3'b101);
        if (target >= 3) send(3'b010);
        if (target >= 4) send(3'b001);
    endtask

    initial begin
        // reachable-state by event-code sweep: R3 R4 R5 R6
        for (int tgt = 0; tgt < 5; tgt++) begin
            for (int ev = 0; ev < 8; ev++) begin
                do_reset();
                prefix(tgt);
                send(3'(ev));
            end
        end
        // R6: repeated activation while T active, then resume T
        do_reset();
        prefix(4);
        send(3'b101);
        send(3'b101);
        send(3'b010);
        chk(run_thread == 1'b1 && sys_state == 3'd3, "R6", "T resumed", int'(sys_state), 3);
        // R7: hold with no event, including while event_code toggles
        begin
            logic [2:0] s0;
            logic t0;
            s0 = sys_state;
            t0 = run_thread;
            for (int i = 0; i < 6; i++) begin
                event_code = 3'(i);
                @(negedge clk);
            end
            chk(sys_state == s0 && run_thread == t0, "R7", "hold without event",
                int'({sys_state, run_thread}), int'({s0, t0}));
            chk(!out_valid && !resched && !bad_event, "R7", "no spurious result",
                int'({out_valid, resched, bad_event}), 0);
        end
        // full cycle back to idle
        send(3'b011);
        chk(sys_state == 3'd0 && run_thread == 1'b0, "R3", "terminate to idle",
            int'(sys_state), 0);
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule